// File: doc/BRIEF.md
# Configurable Fault Escalation and Capture Unit

This unit sits beside a processor pipeline and receives one synchronous fault report per cycle at most. A report names a fault class (memory protection, bus or usage), may carry a faulting address, and may be flagged as raised while the pipeline was pushing the stack frame for entry into some handler. From the per-class programmable priorities and enables, the current execution level and the state of the fixed-priority handlers, the unit decides one outcome. The outcome is the fault's own handler, a promotion to the fixed hard-fault handler, or a lockup report when no handler can be entered.

The decision is registered and appears as a one-cycle pulse on the output the cycle after the report. In the same edge the unit records sticky cause bits in four small status registers and latches faulting addresses into two address registers. Each address register has its own valid flag. Software clears the status bits by writing ones to them. Clearing the cause bit of a class also drops the valid flag of that class's address register.

Top module: `fault_escalate`

## Requirements
- R1: Each accepted report (`flt_valid` high with `flt_kind` 0 = memory protection, 1 = bus, 2 = usage) produces exactly one pulse, one cycle later, on one of `go_cfg`, `go_hard` or `lockup`. `go_kind` repeats the class. A report with `flt_kind` 3 produces no pulse and changes no status or address register.
- R2: If `hf_active` or `nmi_active` is high, the report yields `lockup`. In that case `hsr[1]` is set.
- R3: Otherwise, a report of class bus, flagged `flt_stk` with `flt_stk_tgt` = 1 (stacking for entry to the bus handler), always yields `go_cfg`. This holds whatever the enable or priority.
- R4: Otherwise, if the enable of the class is low, the report yields `go_hard`.
- R5: Otherwise, if `in_handler` is high and the class priority is numerically greater than or equal to `cur_prio`, the report yields `go_hard`. Lower numbers are more urgent.
- R6: Otherwise the report yields `go_cfg`.
- R7: Every `go_hard` sets `hsr[0]` (forced). Every accepted report, whatever its outcome, sets bit 0 of its class status register (`msr`, `bsr`, `usr`). It also copies `flt_stk` into bit 1 of that register.
- R8: A memory-protection report with `flt_addr_ok` loads `mar` and sets `mar_ok`. A bus report with `flt_addr_ok` loads `bar` and sets `bar_ok`. No other report changes either address register.
- R9: A write with `wr_en` clears each bit of the register picked by `wr_sel` (0 = `hsr`, 1 = `msr`, 2 = `bsr`, 3 = `usr`) where `wr_data` is 1. Other bits and registers are unchanged. A bit being set by a report in the same cycle stays set.
- R10: Clearing bit 0 of `msr` clears `mar_ok`, and clearing bit 0 of `bsr` clears `bar_ok`. This does not happen if the same cycle captures a new address. Clearing only bit 1 leaves the valid flags alone.
- R11: After reset, all status bits, valid flags and outcome pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault report present this cycle |
| flt_kind | input | 2 | 0 memory protection, 1 bus, 2 usage, 3 none |
| flt_addr | input | AW | Faulting address |
| flt_addr_ok | input | 1 | `flt_addr` is meaningful |
| flt_stk | input | 1 | Fault raised during entry stacking |
| flt_stk_tgt | input | 2 | Class of handler being entered while stacking |
| prio_mem | input | PW | Memory protection fault priority |
| prio_bus | input | PW | Bus fault priority |
| prio_usg | input | PW | Usage fault priority |
| en_mem | input | 1 | Memory protection handler enable |
| en_bus | input | 1 | Bus fault handler enable |
| en_usg | input | 1 | Usage fault handler enable |
| in_handler | input | 1 | An exception handler is executing |
| cur_prio | input | PW | Priority of the executing handler |
| hf_active | input | 1 | Hard fault handler active |
| nmi_active | input | 1 | NMI handler active |
| wr_en | input | 1 | Status write strobe |
| wr_sel | input | 2 | Status register selected for write |
| wr_data | input | 2 | Write-one-to-clear mask |
| go_cfg | output | 1 | Enter the fault's own handler |
| go_hard | output | 1 | Enter the hard fault handler |
| lockup | output | 1 | No handler can be entered |
| go_kind | output | 2 | Class of the decided fault |
| hsr | output | 2 | Hard fault status: [0] forced, [1] lockup seen |
| msr | output | 2 | Memory protection status: [0] fault, [1] stacking |
| bsr | output | 2 | Bus status: [0] fault, [1] stacking |
| usr | output | 2 | Usage status: [0] fault, [1] stacking |
| mar | output | AW | Memory protection fault address |
| mar_ok | output | 1 | `mar` holds a captured address |
| bar | output | AW | Bus fault address |
| bar_ok | output | 1 | `bar` holds a captured address |

## Verification
The bench sweeps every class, four priorities against four current levels, both handler states, both enables, both stacking flags and targets, and the three states of the fixed handlers. The equality case of priority is where an off-by-one comparison would let a handler preempt itself instead of promoting. The bus-into-bus stacking case would wrongly promote if the exemption were ordered after the enable test. A fault under NMI would re-enter hard fault if only `hf_active` were honoured. Separate cases cover a clear that coincides with a capture, and a clear of the stacking bit alone. A faulty design would drop the new cause in the first case and lose the address valid flag in the second.

// File: rtl/fault_escalate.sv
module fault_escalate #(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_valid,
  input  logic [1:0]    flt_kind,
  input  logic [AW-1:0] flt_addr,
  input  logic          flt_addr_ok,
  input  logic          flt_stk,
  input  logic [1:0]    flt_stk_tgt,
  input  logic [PW-1:0] prio_mem,
  input  logic [PW-1:0] prio_bus,
  input  logic [PW-1:0] prio_usg,
  input  logic          en_mem,
  input  logic          en_bus,
  input  logic          en_usg,
  input  logic          in_handler,
  input  logic [PW-1:0] cur_prio,
  input  logic          hf_active,
  input  logic          nmi_active,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [1:0]    wr_data,
  output logic          go_cfg,
  output logic          go_hard,
  output logic          lockup,
  output logic [1:0]    go_kind,
  output logic [1:0]    hsr,
  output logic [1:0]    msr,
  output logic [1:0]    bsr,
  output logic [1:0]    usr,
  output logic [AW-1:0] mar,
  output logic          mar_ok,
  output logic [AW-1:0] bar,
  output logic          bar_ok
);

  localparam logic [1:0] K_MEM = 2'd0;
  localparam logic [1:0] K_BUS = 2'd1;
  localparam logic [1:0] K_USG = 2'd2;

  logic          take;
  logic [PW-1:0] f_prio;
  logic          f_en;
  logic          blocked, exempt, promote;
  logic          d_cfg, d_hard, d_lock;

  assign take = flt_valid && (flt_kind != 2'd3);

  always_comb begin
    case (flt_kind)
      K_MEM:   begin f_prio = prio_mem; f_en = en_mem; end
      K_BUS:   begin f_prio = prio_bus; f_en = en_bus; end
      default: begin f_prio = prio_usg; f_en = en_usg; end
    endcase
  end

  assign blocked = hf_active || nmi_active;
  assign exempt  = (flt_kind == K_BUS) && flt_stk && (flt_stk_tgt == K_BUS);
  assign promote = !f_en || (in_handler && (f_prio >= cur_prio));
  assign d_lock  = take && blocked;
  assign d_cfg   = take && !blocked && (exempt || !promote);
  assign d_hard  = take && !blocked && !exempt && promote;

  logic [1:0] clr_h, clr_m, clr_b, clr_u;
  logic [1:0] set_h, set_m, set_b, set_u;
  logic       cap_m, cap_b;

  assign clr_h = (wr_en && wr_sel == 2'd0) ? wr_data : 2'b00;
  assign clr_m = (wr_en && wr_sel == 2'd1) ? wr_data : 2'b00;
  assign clr_b = (wr_en && wr_sel == 2'd2) ? wr_data : 2'b00;
  assign clr_u = (wr_en && wr_sel == 2'd3) ? wr_data : 2'b00;

  assign set_h = {d_lock, d_hard};
  assign set_m = (take && flt_kind == K_MEM) ? {flt_stk, 1'b1} : 2'b00;
  assign set_b = (take && flt_kind == K_BUS) ? {flt_stk, 1'b1} : 2'b00;
  assign set_u = (take && flt_kind == K_USG) ? {flt_stk, 1'b1} : 2'b00;
  assign cap_m = take && flt_kind == K_MEM && flt_addr_ok;
  assign cap_b = take && flt_kind == K_BUS && flt_addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_cfg  <= 1'b0;
      go_hard <= 1'b0;
      lockup  <= 1'b0;
      go_kind <= 2'd0;
      hsr     <= 2'b00;
      msr     <= 2'b00;
      bsr     <= 2'b00;
      usr     <= 2'b00;
      mar     <= '0;
      bar     <= '0;
      mar_ok  <= 1'b0;
      bar_ok  <= 1'b0;
    end else begin
      go_cfg  <= d_cfg;
      go_hard <= d_hard;
      lockup  <= d_lock;
      if (take) go_kind <= flt_kind;
      hsr <= (hsr & ~clr_h) | set_h;
      msr <= (msr & ~clr_m) | set_m;
      bsr <= (bsr & ~clr_b) | set_b;
      usr <= (usr & ~clr_u) | set_u;
      if (cap_m)         begin mar <= flt_addr; mar_ok <= 1'b1; end
      else if (clr_m[0]) mar_ok <= 1'b0;
      if (cap_b)         begin bar <= flt_addr; bar_ok <= 1'b1; end
      else if (clr_b[0]) bar_ok <= 1'b0;
    end
  end

  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_cfg, go_hard, lockup}));

  a_r1_needs_report: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && flt_kind != 2'd3 |=> (go_cfg || go_hard || lockup));

  a_r2_lockup_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_kind != 2'd3 && (hf_active || nmi_active)) |=> lockup);

  a_r3_bus_stack_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_kind == 2'd1 && flt_stk && flt_stk_tgt == 2'd1 && !hf_active && !nmi_active)
      |=> go_cfg);

  a_r7_forced_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    go_hard |-> hsr[0]);

  a_r10_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mar_ok) |-> $past(wr_en && wr_sel == 2'd1 && wr_data[0]));

endmodule

// File: tb/tb_fault_escalate.sv
module tb_fault_escalate;
  localparam int AW = 32;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_valid = 0, flt_addr_ok = 0, flt_stk = 0;
  logic [1:0] flt_kind = 0, flt_stk_tgt = 0;
  logic [AW-1:0] flt_addr = 0;
  logic [PW-1:0] prio_mem = 0, prio_bus = 0, prio_usg = 0, cur_prio = 0;
  logic en_mem = 0, en_bus = 0, en_usg = 0, in_handler = 0, hf_active = 0, nmi_active = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, wr_data = 0;
  logic go_cfg, go_hard, lockup, mar_ok, bar_ok;
  logic [1:0] go_kind, hsr, msr, bsr, usr;
  logic [AW-1:0] mar, bar;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_escalate #(.AW(AW), .PW(PW)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 2'b11;
    for (int s = 0; s < 4; s++) begin wr_sel = s[1:0]; tick(); end
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R11 go_cfg", go_cfg, 0); chk("R11 go_hard", go_hard, 0); chk("R11 lockup", lockup, 0);
    chk("R11 status", {hsr, msr, bsr, usr}, 0); chk("R11 valid", {mar_ok, bar_ok}, 0);
    @(negedge clk); rst_n = 1; tick();

    for (int k = 0; k < 4; k++)
    for (int fp = 0; fp < 4; fp++)
    for (int cp = 0; cp < 4; cp++)
    for (int ih = 0; ih < 2; ih++)
    for (int en = 0; en < 2; en++)
    for (int st = 0; st < 2; st++)
    for (int tb = 0; tb < 2; tb++)
    for (int hs = 0; hs < 3; hs++) begin
      logic ex_c, ex_h, ex_l, take, ao;
      logic [AW-1:0] a;
      a = 32'h1000_0000 + (k << 12) + (fp << 8) + (cp << 4) + hs;
      ao = (fp + cp + ih) % 2 == 0;
      take = (k != 3);
      ex_l = take && hs != 0;
      ex_c = take && hs == 0 && ((k == 1 && st == 1 && tb == 1) || (en == 1 && !(ih == 1 && fp >= cp)));
      ex_h = take && hs == 0 && !ex_c;
      flt_kind = k[1:0]; prio_mem = fp[7:0]; prio_bus = fp[7:0]; prio_usg = fp[7:0];
      cur_prio = cp[7:0]; in_handler = ih[0]; en_mem = en[0]; en_bus = en[0]; en_usg = en[0];
      flt_stk = st[0]; flt_stk_tgt = tb ? 2'd1 : 2'd2; hf_active = (hs == 1); nmi_active = (hs == 2);
      flt_addr = a; flt_addr_ok = ao; flt_valid = 1;
      tick();
      flt_valid = 0;
      if (k == 3) begin
        chk("R1 kind3 no pulse", {go_cfg, go_hard, lockup}, 0);
        chk("R1 kind3 no status", {hsr, msr, bsr, usr, mar_ok, bar_ok}, 0);
      end else begin
        chk(hs != 0 ? "R2 lockup" : (k == 1 && st == 1 && tb == 1) ? "R3 bus stack" :
            en == 0 ? "R4 disabled" : ex_h ? "R5 priority" : "R6 own handler",
            {go_cfg, go_hard, lockup}, {ex_c, ex_h, ex_l});
        chk("R1 go_kind", go_kind, k[1:0]);
        chk("R7 hsr", hsr, {ex_l, ex_h});
        chk("R7 class status", k == 0 ? msr : k == 1 ? bsr : usr, {st[0], 1'b1});
        chk("R8 mem valid", mar_ok, k == 0 && ao);
        chk("R8 bus valid", bar_ok, k == 1 && ao);
        if (k == 0 && ao) chk("R8 mar", mar, a);
        if (k == 1 && ao) chk("R8 bar", bar, a);
      end
      clear_all();
      if (k != 3 && hs == 0 && fp == 0 && cp == 0 && ih == 0 && en == 0 && st == 0 && tb == 0)
        chk("R9 R10 cleared", {hsr, msr, bsr, usr, mar_ok, bar_ok}, 0);
    end

    hf_active = 0; nmi_active = 0; en_bus = 1; in_handler = 0;
    flt_kind = 1; flt_stk = 1; flt_stk_tgt = 2; flt_addr = 32'hABCD_0000; flt_addr_ok = 1; flt_valid = 1;
    tick(); flt_valid = 0;
    wr_en = 1; wr_sel = 2; wr_data = 2'b10; tick(); wr_en = 0;
    chk("R10 bit1 clear keeps valid", {bsr, bar_ok}, 3'b011);
    wr_en = 1; wr_sel = 1; wr_data = 2'b11; tick(); wr_en = 0;
    chk("R9 other reg untouched", {bsr, bar_ok}, 3'b011);
    flt_valid = 1; flt_stk = 0; flt_addr = 32'h0000_BEEF;
    wr_en = 1; wr_sel = 2; wr_data = 2'b11; tick(); flt_valid = 0; wr_en = 0;
    chk("R9 set beats clear", bsr, 2'b01);
    chk("R10 capture beats clear", {bar_ok, bar}, {1'b1, 32'h0000_BEEF});
    wr_en = 1; wr_sel = 2; wr_data = 2'b01; tick(); wr_en = 0;
    chk("R10 valid drop", {bsr, bar_ok}, 3'b000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule